// File: doc/BRIEF.md
# Camera Sensor Bring-Up Sequencer

This block powers up an image sensor without processor help. On a start pulse it programs the control bridge with an enable code and the sensor's bus address. It then writes the sensor's soft-reset bit and waits for a settle time. Next it reads the two manufacturer identity bytes and compares them with the expected pair. If they match, it walks an internal table of register/value byte pairs and writes each pair, stopping at the end marker. A second settle time follows, and then it reports completion.

Every request leaves the block on a valid/ready channel. The fields `req_kind`, `req_addr` and `req_data` must be held while `req_valid` is high and `req_ready` is low. A transfer takes place on the first clock where both are high. A bridge-configuration request is complete at its handshake. A sensor write or sensor read is followed by status polls. The block raises `poll_strobe` for one cycle per poll. The bridge answers each poll with one `stat_valid` cycle carrying `stat_code`, and the block always accepts that answer. Only one poll is outstanding at a time. Status codes are: 0x00 means still busy, 0x04 means a write completed, and 0x01 means a read completed (with the byte on `stat_rdata`).

Top module: `init_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `req_valid` and `poll_strobe` are low and `result` is 0. A `start` pulse while idle begins a run. A `start` while `busy` is high has no effect on the request stream or on the number of `done` pulses.
- R2: A run opens with three requests, in this order:
  - bridge configuration (kind 0), address 0, data 0x1E;
  - bridge configuration (kind 0), address 1, data 0x60;
  - sensor write (kind 1), register 0x12, value 0x80.
- R3: After the reset write completes, no request is issued for at least DELAY_CYCLES clock cycles.
- R4: Two sensor reads (kind 2, data 0) then follow, of register 0x1C and then register 0x1D. Unless the returned bytes are 0x7F and 0xA2 respectively, the run ends with result 2 and issues no further request.
- R5: The table is written with sensor writes in this order: 0x11/0x80, 0x3B/0x01, 0x10/0x40, 0xFF/0x00, 0x13/0x45. Only an entry whose register and value are both 0xFF ends the walk, and that entry itself is never sent.
- R6: After the last table write completes, `done` rises no earlier than DELAY_CYCLES cycles later.
- R7: After each sensor transfer handshake, polls are issued one at a time, with each poll waiting for its answer. A transfer whose MAX_POLLS-th answer is the correct code still succeeds.
- R8: If MAX_POLLS answers in a row are 0x00, the run ends with result 1. No further poll or request follows.
- R9: A nonzero answer other than the expected code ends the run with result 1 at once. A write expects 0x04 and a read expects 0x01. A failure during the table walk aborts the walk.
- R10: `done` is a single-cycle pulse. `busy` is low in that cycle. `result` (0 ok, 1 transfer error, 2 identity mismatch) is valid with `done` and holds until the next run ends.
- R11: Request fields stay stable while `req_valid` is high and `req_ready` is low. Bridge-configuration requests are never followed by polls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 ok, 1 transfer error, 2 identity mismatch |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Bridge accepts request |
| req_kind | output | 2 | 0 bridge config, 1 sensor write, 2 sensor read |
| req_addr | output | 8 | Bridge index or sensor register |
| req_data | output | 8 | Data to write |
| poll_strobe | output | 1 | One-cycle status poll |
| stat_valid | input | 1 | Poll answer present |
| stat_code | input | 8 | Poll answer status code |
| stat_rdata | input | 8 | Read byte, valid with a read-complete code |

## Verification
Suppose the top-level state register or the table index went wrong. The very next handshake would show a request with the wrong kind, register or value, so the in-order request scoreboard catches it within one transfer. A fault in the poll counter shows up as the wrong number of poll strobes at the timeout boundary: one poll early or late decides between success and result 1 when the run ends. A delay counter that runs short is caught by the measured gap between a completing status answer and the next request or `done`.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [1:0] {XK_CFG = 2'd0, XK_WR = 2'd1, XK_RD = 2'd2} xkind_t;
  typedef enum logic [1:0] {RC_OK = 2'd0, RC_XFER = 2'd1, RC_ID = 2'd2} rcode_t;
  localparam logic [7:0] ST_BUSY  = 8'h00;
  localparam logic [7:0] ST_WR_OK = 8'h04;
  localparam logic [7:0] ST_RD_OK = 8'h01;
  localparam logic [7:0] END_BYTE = 8'hFF;
endpackage

// File: rtl/sis_rom.sv
module sis_rom #(
  parameter int ROM_AW = 3
) (
  input  logic [ROM_AW-1:0] idx,
  output logic [7:0]        reg_addr,
  output logic [7:0]        reg_val
);
  always_comb begin
    case (idx)
      ROM_AW'(0): {reg_addr, reg_val} = {8'h11, 8'h80};
      ROM_AW'(1): {reg_addr, reg_val} = {8'h3B, 8'h01};
      ROM_AW'(2): {reg_addr, reg_val} = {8'h10, 8'h40};
      ROM_AW'(3): {reg_addr, reg_val} = {8'hFF, 8'h00};
      ROM_AW'(4): {reg_addr, reg_val} = {8'h13, 8'h45};
      default:    {reg_addr, reg_val} = {8'hFF, 8'hFF};
    endcase
  end
endmodule

// File: rtl/sis_delay.sv
module sis_delay #(
  parameter int DELAY_CYCLES = 480000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int DW = $clog2(DELAY_CYCLES + 1);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        cnt <= DW'(DELAY_CYCLES);
      end else if (cnt != '0) begin
        cnt     <= cnt - 1'b1;
        expired <= (cnt == DW'(1));
      end
    end
  end

  a_r3_expire_single: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !expired);
endmodule

// File: rtl/sis_xfer.sv
module sis_xfer
  import sis_pkg::*;
#(
  parameter int MAX_POLLS = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [1:0] kind_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] data_i,
  output logic       req_valid,
  input  logic       req_ready,
  output logic [1:0] req_kind,
  output logic [7:0] req_addr,
  output logic [7:0] req_data,
  output logic       poll_strobe,
  input  logic       stat_valid,
  input  logic [7:0] stat_code,
  input  logic [7:0] stat_rdata,
  output logic       fin,
  output logic       fin_ok,
  output logic [7:0] rdata
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  typedef enum logic [1:0] {XS_IDLE, XS_REQ, XS_POLL, XS_WAIT} xs_t;

  xs_t          st;
  logic [1:0]   k_q;
  logic [7:0]   a_q, d_q;
  logic [PW-1:0] pcnt;
  logic [7:0]   want;

  assign want        = (k_q == XK_RD) ? ST_RD_OK : ST_WR_OK;
  assign req_valid   = (st == XS_REQ);
  assign poll_strobe = (st == XS_POLL);
  assign req_kind    = k_q;
  assign req_addr    = a_q;
  assign req_data    = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= XS_IDLE;
      k_q    <= '0;
      a_q    <= '0;
      d_q    <= '0;
      pcnt   <= '0;
      fin    <= 1'b0;
      fin_ok <= 1'b0;
      rdata  <= '0;
    end else begin
      fin    <= 1'b0;
      fin_ok <= 1'b0;
      case (st)
        XS_IDLE: if (go) begin
          k_q <= kind_i;
          a_q <= addr_i;
          d_q <= data_i;
          st  <= XS_REQ;
        end
        XS_REQ: if (req_ready) begin
          if (k_q == XK_CFG) begin
            fin    <= 1'b1;
            fin_ok <= 1'b1;
            st     <= XS_IDLE;
          end else begin
            pcnt <= '0;
            st   <= XS_POLL;
          end
        end
        XS_POLL: begin
          pcnt <= pcnt + 1'b1;
          st   <= XS_WAIT;
        end
        XS_WAIT: if (stat_valid) begin
          if (stat_code == ST_BUSY) begin
            if (pcnt == PW'(MAX_POLLS)) begin
              fin <= 1'b1;
              st  <= XS_IDLE;
            end else begin
              st <= XS_POLL;
            end
          end else begin
            fin    <= 1'b1;
            fin_ok <= (stat_code == want);
            rdata  <= stat_rdata;
            st     <= XS_IDLE;
          end
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_kind)
                                && $stable(req_addr) && $stable(req_data));
  a_r7_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PW'(MAX_POLLS));
  a_r7_poll_single: assert property (@(posedge clk) disable iff (!rst_n)
    poll_strobe |=> !poll_strobe && !req_valid);
  a_r11_cfg_nopoll: assert property (@(posedge clk) disable iff (!rst_n)
    poll_strobe |-> k_q != XK_CFG);
endmodule

// File: rtl/init_sequencer.sv
module init_sequencer
  import sis_pkg::*;
#(
  parameter int          DELAY_CYCLES = 480000,
  parameter int          MAX_POLLS    = 50,
  parameter int          ROM_AW       = 3,
  parameter logic [7:0]  BRIDGE_EN    = 8'h1E,
  parameter logic [7:0]  SLAVE_ADDR   = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic [1:0] result,
  output logic       req_valid,
  input  logic       req_ready,
  output logic [1:0] req_kind,
  output logic [7:0] req_addr,
  output logic [7:0] req_data,
  output logic       poll_strobe,
  input  logic       stat_valid,
  input  logic [7:0] stat_code,
  input  logic [7:0] stat_rdata
);
  localparam logic [7:0] RST_REG  = 8'h12;
  localparam logic [7:0] RST_VAL  = 8'h80;
  localparam logic [7:0] IDH_REG  = 8'h1C;
  localparam logic [7:0] IDL_REG  = 8'h1D;
  localparam logic [7:0] IDH_WANT = 8'h7F;
  localparam logic [7:0] IDL_WANT = 8'hA2;

  typedef enum logic [3:0] {
    T_IDLE, T_EN, T_SADDR, T_RST, T_DLY1, T_IDH, T_IDL, T_TBL, T_DLY2
  } tst_t;

  tst_t              st;
  logic              pend;
  logic [ROM_AW-1:0] idx;
  logic [7:0]        idh_q;
  rcode_t            res_q;
  logic [7:0]        rom_reg, rom_val;
  logic              at_end, xstate, go, dly_start, dly_exp;
  logic [1:0]        x_kind;
  logic [7:0]        x_addr, x_data, x_rdata;
  logic              x_fin, x_ok;

  sis_rom #(.ROM_AW(ROM_AW)) u_rom (.idx(idx), .reg_addr(rom_reg), .reg_val(rom_val));

  assign at_end = (rom_reg == END_BYTE) && (rom_val == END_BYTE);
  assign xstate = (st == T_EN) || (st == T_SADDR) || (st == T_RST) ||
                  (st == T_IDH) || (st == T_IDL) || ((st == T_TBL) && !at_end);
  assign go     = xstate && !pend && !x_fin;

  always_comb begin
    x_kind = XK_WR;
    x_addr = rom_reg;
    x_data = rom_val;
    case (st)
      T_EN:    begin x_kind = XK_CFG; x_addr = 8'd0;    x_data = BRIDGE_EN;  end
      T_SADDR: begin x_kind = XK_CFG; x_addr = 8'd1;    x_data = SLAVE_ADDR; end
      T_RST:   begin x_kind = XK_WR;  x_addr = RST_REG; x_data = RST_VAL;    end
      T_IDH:   begin x_kind = XK_RD;  x_addr = IDH_REG; x_data = 8'h00;      end
      T_IDL:   begin x_kind = XK_RD;  x_addr = IDL_REG; x_data = 8'h00;      end
      default: ;
    endcase
  end

  assign dly_start = ((st == T_RST) && x_fin && x_ok) ||
                     ((st == T_TBL) && !pend && !x_fin && at_end);

  sis_xfer #(.MAX_POLLS(MAX_POLLS)) u_xfer (
    .clk(clk), .rst_n(rst_n), .go(go), .kind_i(x_kind), .addr_i(x_addr),
    .data_i(x_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .poll_strobe(poll_strobe), .stat_valid(stat_valid), .stat_code(stat_code),
    .stat_rdata(stat_rdata), .fin(x_fin), .fin_ok(x_ok), .rdata(x_rdata)
  );

  sis_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
    .clk(clk), .rst_n(rst_n), .start(dly_start), .expired(dly_exp)
  );

  assign busy   = (st != T_IDLE);
  assign result = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= T_IDLE;
      pend  <= 1'b0;
      idx   <= '0;
      idh_q <= '0;
      res_q <= RC_OK;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go)    pend <= 1'b1;
      if (x_fin) pend <= 1'b0;
      if (x_fin && !x_ok) begin
        st    <= T_IDLE;
        done  <= 1'b1;
        res_q <= RC_XFER;
      end else begin
        case (st)
          T_IDLE:  if (start) begin st <= T_EN; idx <= '0; end
          T_EN:    if (x_fin) st <= T_SADDR;
          T_SADDR: if (x_fin) st <= T_RST;
          T_RST:   if (x_fin) st <= T_DLY1;
          T_DLY1:  if (dly_exp) st <= T_IDH;
          T_IDH:   if (x_fin) begin idh_q <= x_rdata; st <= T_IDL; end
          T_IDL:   if (x_fin) begin
            if (idh_q == IDH_WANT && x_rdata == IDL_WANT) begin
              st <= T_TBL;
            end else begin
              st    <= T_IDLE;
              done  <= 1'b1;
              res_q <= RC_ID;
            end
          end
          T_TBL: begin
            if (x_fin) idx <= idx + 1'b1;
            else if (!pend && at_end) st <= T_DLY2;
          end
          T_DLY2: if (dly_exp) begin
            st    <= T_IDLE;
            done  <= 1'b1;
            res_q <= RC_OK;
          end
          default: st <= T_IDLE;
        endcase
      end
    end
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !poll_strobe);
  a_r3_delay_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_DLY1 || st == T_DLY2) |-> !req_valid && !poll_strobe);
  a_r5_no_marker_sent: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == XK_WR |-> !(req_addr == END_BYTE && req_data == END_BYTE));
endmodule

// File: tb/sim_init_sequencer.sv
module sim_init_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DLY   = 20;
  localparam int MAXP  = 50;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, req_valid, poll_strobe;
  logic [1:0] result, req_kind;
  logic [7:0] req_addr, req_data;
  logic req_ready = 1'b0, stat_valid = 1'b0;
  logic [7:0] stat_code = 8'h00, stat_rdata = 8'h00;

  init_sequencer #(.DELAY_CYCLES(DLY), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .result(result), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .poll_strobe(poll_strobe), .stat_valid(stat_valid), .stat_code(stat_code),
    .stat_rdata(stat_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [17:0] expq[$];

  // bridge model configuration
  int bp = 0, busy_polls = 0, fault_xfer = -1;
  logic [7:0] fault_code = 8'h00, id_hi = 8'h7F, id_lo = 8'hA2;
  // model state
  int cyc = 0, xfer_n = 0, cur_x = -1, polls_this = 0, total_polls = 0;
  int done_cnt = 0, ok_cyc = 0, gap_rst = -1, gap_end = -1, busy_at_done = 0;
  int resp_pend = 0;
  logic [1:0] cur_kind = 2'd0;
  logic [7:0] cur_addr = 8'h00;

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [1:0] k, input logic [7:0] a, input logic [7:0] d);
    expq.push_back({k, a, d});
  endtask

  task automatic push_prefix(input int upto);
    // upto: number of requests from the fixed prefix of R2/R4
    if (upto > 0) push_exp(2'd0, 8'd0, 8'h1E);
    if (upto > 1) push_exp(2'd0, 8'd1, 8'h60);
    if (upto > 2) push_exp(2'd1, 8'h12, 8'h80);
    if (upto > 3) push_exp(2'd2, 8'h1C, 8'h00);
    if (upto > 4) push_exp(2'd2, 8'h1D, 8'h00);
  endtask

  task automatic push_table(input int n);
    logic [15:0] tbl [5] = '{16'h1180, 16'h3B01, 16'h1040, 16'hFF00, 16'h1345};
    for (int i = 0; i < n; i++) push_exp(2'd1, tbl[i][15:8], tbl[i][7:0]);
  endtask

  // monitor and bridge model, all away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (done) begin
      done_cnt++;
      if (busy) busy_at_done++;
      gap_end = cyc - ok_cyc;
    end
    if (resp_pend != 0) begin
      stat_valid = 1'b1;
      if (cur_x == fault_xfer) stat_code = fault_code;
      else if (polls_this <= busy_polls) stat_code = 8'h00;
      else stat_code = (cur_kind == 2'd2) ? 8'h01 : 8'h04;
      stat_rdata = (cur_addr == 8'h1C) ? id_hi : (cur_addr == 8'h1D) ? id_lo : 8'h00;
      if (stat_code != 8'h00) ok_cyc = cyc;
      resp_pend = 0;
    end else begin
      stat_valid = 1'b0;
    end
    if (poll_strobe) begin
      polls_this++;
      total_polls++;
      resp_pend = 1;
    end
    req_ready = (bp != 0) ? (cyc % 3 == 0) : 1'b1;
    if (req_valid && req_ready) begin
      if (cur_addr == 8'h12 && cur_kind == 2'd1 && gap_rst < 0) gap_rst = cyc - ok_cyc;
      if (expq.size() == 0) begin
        check(1'b0, "R2", "unexpected request", {req_kind, req_addr, req_data}, 0);
      end else begin
        logic [17:0] e;
        e = expq.pop_front();
        check({req_kind, req_addr, req_data} == e, "R5", "request order",
              {req_kind, req_addr, req_data}, e);
      end
      if (req_kind != 2'd0) begin
        cur_x = xfer_n;
        xfer_n++;
        polls_this = 0;
      end
      cur_kind = req_kind;
      cur_addr = req_addr;
    end
  end

  task automatic setup(input int b, input int bpl, input int fx, input logic [7:0] fc,
                       input logic [7:0] h, input logic [7:0] l);
    bp = b; busy_polls = bpl; fault_xfer = fx; fault_code = fc; id_hi = h; id_lo = l;
    xfer_n = 0; cur_x = -1; total_polls = 0; done_cnt = 0; busy_at_done = 0;
    gap_rst = -1; gap_end = -1; cur_addr = 8'h00; cur_kind = 2'd0;
  endtask

  task automatic run(input string req, input logic [1:0] exp_res, input bit restart);
    int n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (restart) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (done_cnt == 0 && n < 20000) begin @(negedge clk); n++; end
    repeat (40) @(negedge clk);
    check(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    check(busy_at_done == 0, "R10", "busy at done", busy_at_done, 0);
    check(result == exp_res, req, "result code", result, exp_res);
    check(expq.size() == 0, req, "requests missing", expq.size(), 0);
    check(!busy, "R1", "busy after run", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !req_valid && !poll_strobe, "R1", "idle outputs",
          {busy, done, req_valid, poll_strobe}, 0);
    check(result == 2'd0, "R1", "reset result", result, 0);

    // normal run with back-pressure, 2 busy polls each, restart while busy (R1, R2, R5, R7, R11)
    setup(1, 2, -1, 8'h00, 8'h7F, 8'hA2);
    push_prefix(5); push_table(5);
    run("R5", 2'd0, 1'b1);
    check(total_polls == 24, "R11", "poll count (sensor only)", total_polls, 24);
    check(gap_rst >= DLY && gap_rst <= DLY + 8, "R3", "post-reset gap", gap_rst, DLY);
    check(gap_end >= DLY && gap_end <= DLY + 8, "R6", "final gap", gap_end, DLY);

    // R7 boundary: answer correct on the last allowed poll
    setup(0, MAXP - 1, -1, 8'h00, 8'h7F, 8'hA2);
    push_prefix(5); push_table(5);
    run("R7", 2'd0, 1'b0);
    check(total_polls == 8 * MAXP, "R7", "polls at limit", total_polls, 8 * MAXP);

    // R8 timeout on the reset write
    setup(0, MAXP, -1, 8'h00, 8'h7F, 8'hA2);
    push_prefix(3);
    run("R8", 2'd1, 1'b0);
    check(polls_this == MAXP, "R8", "polls before timeout", polls_this, MAXP);

    // R9 bad code on the third table write aborts the walk
    setup(1, 1, 5, 8'h02, 8'h7F, 8'hA2);
    push_prefix(5); push_table(3);
    run("R9", 2'd1, 1'b0);

    // R9 read answered with the write code
    setup(0, 0, 1, 8'h04, 8'h7F, 8'hA2);
    push_prefix(4);
    run("R9", 2'd1, 1'b0);

    // R4 low identity byte wrong
    setup(0, 0, -1, 8'h00, 8'h7F, 8'hA3);
    push_prefix(5);
    run("R4", 2'd2, 1'b0);

    // R4 high identity byte wrong
    setup(1, 3, -1, 8'h00, 8'h7E, 8'hA2);
    push_prefix(5);
    run("R4", 2'd2, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule